// File: doc/BRIEF.md
# Temperature Limit Status and Alert Monitor

This block watches four signed 8-bit temperature readings, one internal channel and three external channels, that arrive together on a single conversion strobe. Each reading is compared against its own low threshold and its own over-temperature (therm) threshold. The therm comparison uses a release point: the threshold minus one shared hysteresis value. The results feed two 8-bit status registers. The low register keeps its bits until software reads it. The therm register sets and releases its bits by itself.

From these registers the block drives a low summary flag, a therm summary flag, a therm output pin and an alert output. The alert output is gated by a per-channel run-length filter: an under-limit condition must persist for a programmed number of back-to-back conversions before it can raise alert. A mode input selects one of two alert behaviours. In latched mode, low bits hold until the low register is read. In comparator mode, low bits simply track the latest conversion.

Software reads the registers through a strobe and an 8-bit address. The read data appears on the cycle after the strobe.

Top module: `temp_limit_monitor`

## Requirements
- R1: After synchronous reset, both status registers are zero, all four flag and pin outputs are low, and rd_data is zero.
- R2: On a conversion, a channel's low bit is set when its reading is strictly less than its low threshold, using a signed two's-complement compare. The low register is at address 0x36, with bit 0 for the internal channel and bits 1, 2 and 3 for external channels 1, 2 and 3. low_flag is high while any low bit is set.
- R3: In latched mode (comp_mode = 0), low bits stay set until the low register is read. A read returns the pre-read content on rd_data one cycle after the strobe, with bits 7:4 as zero. The same edge clears all low bits and therefore low_flag.
- R4: If a read of 0x36 and a conversion that finds a channel below its threshold share a cycle, that channel's bit is set after the edge. rd_data still shows the content from before the edge.
- R5: In comparator mode (comp_mode = 1), each conversion replaces every low bit with the current compare result. Reads of 0x36 do not clear it.
- R6: Each channel counts consecutive conversions below its threshold, saturating at 16, and resets the count on any conversion that is not below. With alert_count = c, a channel becomes qualified on the conversion where the count reaches c+1. alert_o is high while some channel is both qualified and has its low bit set. In latched mode the qualification clears with the low read; in comparator mode it follows each conversion.
- R7: On a conversion, a channel's therm bit is set when its reading is strictly greater than its therm threshold. The therm register is at address 0x37, with the same bit order as the low register. Reading it does not change it.
- R8: A therm bit clears on a conversion whose reading is strictly below the threshold minus therm_hyst, where therm_hyst is unsigned and the difference is floored at -128. Between the two points the bit holds.
- R9: therm_flag and therm_o are high exactly while any therm bit is set.
- R10: A read of any other address returns zero and changes no state. Between reads, rd_data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: new readings present |
| reading_bus | input | 32 | Four signed readings, channel n at bits 8n+7:8n |
| low_lim_bus | input | 32 | Four signed low thresholds, same packing |
| therm_lim_bus | input | 32 | Four signed therm thresholds, same packing |
| therm_hyst | input | 8 | Unsigned therm hysteresis |
| alert_count | input | 4 | Consecutive conversions required, minus one |
| comp_mode | input | 1 | 0 latched, 1 comparator |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after rd_stb |
| low_flag | output | 1 | Any low bit set |
| therm_flag | output | 1 | Any therm bit set |
| alert_o | output | 1 | Qualified low alert |
| therm_o | output | 1 | Over-temperature pin |

## Verification
Two functions can land on the same edge: the read-clear of the low register and a conversion that sets a low bit. The bench provokes this by strobing a read of 0x36 on every fifth step of each sweep while a conversion is also present. It judges the result twice: rd_data must show the content from before the edge, and the read-back and low_flag afterwards must still show the newly set bit. The sweeps ramp and scramble all four channels through the full signed range under several count, hysteresis and mode settings. This covers a therm read that coincides with an automatic release, and a threshold of -128, where the floored release point can never be crossed.

// File: rtl/temp_lim_pkg.sv
package temp_lim_pkg;

    localparam int TEMP_W = 8;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_LOW_STAT   = 8'h36;
    localparam logic [ADDR_W-1:0] ADDR_THERM_STAT = 8'h37;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic {
        MODE_LATCHED = 1'b0,
        MODE_COMPARE = 1'b1
    } alert_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_THERM = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic below;
        logic qual;
    } low_evt_t;

    // Threshold minus unsigned hysteresis, floored at the most negative value.
    function automatic temp_t release_point(temp_t lim, logic [TEMP_W-1:0] hyst);
        logic signed [TEMP_W+1:0] diff;
        logic signed [TEMP_W+1:0] floor_v;
        diff    = $signed({{2{lim[TEMP_W-1]}}, lim}) - $signed({2'b00, hyst});
        floor_v = $signed({3'b111, {(TEMP_W-1){1'b0}}});
        if (diff < floor_v)
            return {1'b1, {(TEMP_W-1){1'b0}}};
        return diff[TEMP_W-1:0];
    endfunction

endpackage

// File: rtl/tl_low_chan.sv
module tl_low_chan
    import temp_lim_pkg::*;
#(
    parameter int CNT_MAX = 16,
    localparam int SEL_W = $clog2(CNT_MAX),
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv,
    input  temp_t            reading,
    input  temp_t            low_lim,
    input  logic [SEL_W-1:0] cnt_sel,
    input  alert_mode_e      mode,
    input  logic             clr,
    output logic             status,
    output logic             reached
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] need;
    low_evt_t         evt;

    always_comb begin
        evt.below = (reading < low_lim);
        need      = CNT_W'(cnt_sel) + CNT_W'(1);
        cnt_d     = cnt_q;
        if (conv) begin
            if (!evt.below)
                cnt_d = '0;
            else if (cnt_q != CNT_TOP)
                cnt_d = cnt_q + CNT_W'(1);
        end
        evt.qual = evt.below && (cnt_d >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            status  <= 1'b0;
            reached <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (mode == MODE_COMPARE) begin
                if (conv) begin
                    status  <= evt.below;
                    reached <= evt.qual;
                end
            end else begin
                // a new event outranks a read-clear in the same cycle
                status  <= (status  & ~clr) | (conv & evt.below);
                reached <= (reached & ~clr) | (conv & evt.qual);
            end
        end
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (conv && evt.below) |=> status);

    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCHED && !conv && !clr) |=> (status == $past(status)));

    assert_comp_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPARE && conv) |=> (status == $past(evt.below)));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_TOP);

    assert_reach_needs_status_R6: assert property (@(posedge clk) disable iff (rst)
        reached |-> status);

endmodule

// File: rtl/tl_therm_chan.sv
module tl_therm_chan
    import temp_lim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv,
    input  temp_t             reading,
    input  temp_t             therm_lim,
    input  logic [TEMP_W-1:0] hyst,
    output logic              status
);

    temp_t rel;

    always_comb rel = release_point(therm_lim, hyst);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (conv) begin
            if (reading > therm_lim)
                status <= 1'b1;
            else if (reading < rel)
                status <= 1'b0;
        end
    end

    assert_therm_set_R7: assert property (@(posedge clk) disable iff (rst)
        (conv && reading > therm_lim) |=> status);

    assert_therm_release_R8: assert property (@(posedge clk) disable iff (rst)
        (conv && reading < therm_lim && reading < rel) |=> !status);

    assert_therm_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !conv |=> $stable(status));

endmodule

// File: rtl/tl_read_port.sv
module tl_read_port
    import temp_lim_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  alert_mode_e       mode,
    input  logic [NCH-1:0]    low_vec,
    input  logic [NCH-1:0]    therm_vec,
    output logic [REG_W-1:0]  rd_data,
    output logic              low_clr
);

    rd_sel_e          sel;
    logic [REG_W-1:0] low_reg;
    logic [REG_W-1:0] therm_reg;
    logic [REG_W-1:0] mux_val;

    always_comb begin
        if (rd_addr == ADDR_LOW_STAT)
            sel = SEL_LOW;
        else if (rd_addr == ADDR_THERM_STAT)
            sel = SEL_THERM;
        else
            sel = SEL_NONE;

        low_reg   = REG_W'(low_vec);
        therm_reg = REG_W'(therm_vec);

        unique case (sel)
            SEL_LOW:   mux_val = low_reg;
            SEL_THERM: mux_val = therm_reg;
            default:   mux_val = '0;
        endcase

        low_clr = rd_stb && (sel == SEL_LOW) && (mode == MODE_LATCHED);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= mux_val;
    end

    assert_other_addr_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr != ADDR_LOW_STAT && rd_addr != ADDR_THERM_STAT) |=> (rd_data == '0));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
    import temp_lim_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_MAX = 16,
    localparam int SEL_W  = $clog2(CNT_MAX),
    localparam int BUS_W  = NCH * TEMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic [BUS_W-1:0]  reading_bus,
    input  logic [BUS_W-1:0]  low_lim_bus,
    input  logic [BUS_W-1:0]  therm_lim_bus,
    input  logic [TEMP_W-1:0] therm_hyst,
    input  logic [SEL_W-1:0]  alert_count,
    input  logic              comp_mode,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              low_flag,
    output logic              therm_flag,
    output logic              alert_o,
    output logic              therm_o
);

    alert_mode_e    mode;
    logic           low_clr;
    logic [NCH-1:0] low_vec;
    logic [NCH-1:0] reach_vec;
    logic [NCH-1:0] therm_vec;

    always_comb mode = alert_mode_e'(comp_mode);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        temp_t rd_v;
        temp_t lo_v;
        temp_t th_v;

        always_comb begin
            rd_v = reading_bus[ch*TEMP_W +: TEMP_W];
            lo_v = low_lim_bus[ch*TEMP_W +: TEMP_W];
            th_v = therm_lim_bus[ch*TEMP_W +: TEMP_W];
        end

        tl_low_chan #(.CNT_MAX(CNT_MAX)) u_low (
            .clk     (clk),
            .rst     (rst),
            .conv    (conv_valid),
            .reading (rd_v),
            .low_lim (lo_v),
            .cnt_sel (alert_count),
            .mode    (mode),
            .clr     (low_clr),
            .status  (low_vec[ch]),
            .reached (reach_vec[ch])
        );

        tl_therm_chan u_therm (
            .clk       (clk),
            .rst       (rst),
            .conv      (conv_valid),
            .reading   (rd_v),
            .therm_lim (th_v),
            .hyst      (therm_hyst),
            .status    (therm_vec[ch])
        );
    end

    tl_read_port #(.NCH(NCH)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .mode      (mode),
        .low_vec   (low_vec),
        .therm_vec (therm_vec),
        .rd_data   (rd_data),
        .low_clr   (low_clr)
    );

    always_comb begin
        low_flag   = |low_vec;
        therm_flag = |therm_vec;
        therm_o    = |therm_vec;
        alert_o    = |(low_vec & reach_vec);
    end

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == ADDR_LOW_STAT && !comp_mode && !conv_valid) |=> !low_flag);

    assert_alert_needs_low_R6: assert property (@(posedge clk) disable iff (rst)
        alert_o |-> low_flag);

    assert_therm_rise_on_conv_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(therm_o) |-> $past(conv_valid));

    if (NCH < REG_W) begin : g_pad_chk
        assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
            rd_data[REG_W-1:NCH] == '0);
    end

endmodule

// File: tb/temp_limit_monitor_tb_top.sv
`timescale 1ns/1ps
module temp_limit_monitor_tb_top;

    localparam int NCH = 4;
    localparam int TW  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_valid = 1'b0;
    logic [NCH*TW-1:0] reading_bus = '0;
    logic [NCH*TW-1:0] low_lim_bus;
    logic [NCH*TW-1:0] therm_lim_bus;
    logic [7:0]        therm_hyst = 8'd10;
    logic [3:0]        alert_count = 4'd0;
    logic              comp_mode = 1'b0;
    logic              rd_stb = 1'b0;
    logic [7:0]        rd_addr = 8'h00;
    logic [7:0]        rd_data;
    logic              low_flag, therm_flag, alert_o, therm_o;

    always #2.5 clk = ~clk;

    temp_limit_monitor dut_i (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .reading_bus(reading_bus),
        .low_lim_bus(low_lim_bus), .therm_lim_bus(therm_lim_bus), .therm_hyst(therm_hyst),
        .alert_count(alert_count), .comp_mode(comp_mode), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .low_flag(low_flag), .therm_flag(therm_flag),
        .alert_o(alert_o), .therm_o(therm_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit         m_low[NCH];
    bit         m_reach[NCH];
    bit         m_therm[NCH];
    int         m_cnt[NCH];
    logic [7:0] m_rd = 8'h00;
    string      m_tag = "R1 rd_data";

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit any_low = 0, any_alert = 0, any_therm = 0;
        for (int ch = 0; ch < NCH; ch++) begin
            any_low   |= m_low[ch];
            any_alert |= m_low[ch] & m_reach[ch];
            any_therm |= m_therm[ch];
        end
        chk("R2 low_flag", low_flag, any_low);
        chk("R6 alert_o", alert_o, any_alert);
        chk("R9 therm_flag", therm_flag, any_therm);
        chk("R9 therm_o", therm_o, any_therm);
        chk(m_tag, rd_data, m_rd);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit conv, logic [NCH*TW-1:0] vals, bit rd, logic [7:0] addr);
        bit clr;
        int r, ll, tl, relv, need;
        bit below, q;
        conv_valid  = conv;
        reading_bus = vals;
        rd_stb      = rd;
        rd_addr     = addr;
        @(posedge clk);
        if (rd) begin
            m_rd = 8'h00;
            if (addr == 8'h36) begin
                for (int ch = 0; ch < NCH; ch++) m_rd[ch] = m_low[ch];
                m_tag = comp_mode ? "R5 low read" : "R3 low read";
            end else if (addr == 8'h37) begin
                for (int ch = 0; ch < NCH; ch++) m_rd[ch] = m_therm[ch];
                m_tag = "R7 therm read";
            end else begin
                m_tag = "R10 other read";
            end
        end
        clr  = rd && (addr == 8'h36) && !comp_mode;
        need = int'(alert_count) + 1;
        for (int ch = 0; ch < NCH; ch++) begin
            r  = $signed(vals[ch*TW +: TW]);
            ll = $signed(low_lim_bus[ch*TW +: TW]);
            tl = $signed(therm_lim_bus[ch*TW +: TW]);
            relv = tl - int'(therm_hyst);
            if (relv < -128) relv = -128;
            below = (r < ll);
            if (conv) begin
                m_cnt[ch] = below ? ((m_cnt[ch] == 16) ? 16 : m_cnt[ch] + 1) : 0;
                q = below && (m_cnt[ch] >= need);
                if (comp_mode) begin
                    m_low[ch]   = below;
                    m_reach[ch] = q;
                end else begin
                    m_low[ch]   = (m_low[ch] && !clr) || below;
                    m_reach[ch] = (m_reach[ch] && !clr) || q;
                end
                if (r > tl) m_therm[ch] = 1'b1;
                else if (r < relv) m_therm[ch] = 1'b0;
            end else if (clr) begin
                m_low[ch]   = 1'b0;
                m_reach[ch] = 1'b0;
            end
        end
        @(negedge clk);
        conv_valid = 1'b0;
        rd_stb     = 1'b0;
        compare_all();
    endtask

    function automatic logic [NCH*TW-1:0] pat(int kind, int k);
        logic [NCH*TW-1:0] v;
        for (int ch = 0; ch < NCH; ch++) begin
            if (kind == 0) v[ch*TW +: TW] = 8'(k + ch * 40 - 128);
            else           v[ch*TW +: TW] = 8'(k * 73 + ch * 151 + (k / 8) * 29);
        end
        return v;
    endfunction

    task automatic run_pass(bit cmp, int cfg, int hyst, int kind);
        comp_mode   = cmp;
        alert_count = 4'(cfg);
        therm_hyst  = 8'(hyst);
        for (int k = 0; k < 256; k++) begin
            bit rd = 1'b0;
            logic [7:0] a = 8'h00;
            if (k % 5 == 0)       begin rd = 1'b1; a = 8'h36; end
            else if (k % 5 == 2)  begin rd = 1'b1; a = 8'h37; end
            else if (k % 11 == 3) begin rd = 1'b1; a = 8'(8'h30 + k % 7); end
            step((k % 4) != 3, pat(kind, k), rd, a);
        end
    endtask

    function automatic logic [NCH*TW-1:0] pack4(int a, int b, int c, int d);
        return {8'(d), 8'(c), 8'(b), 8'(a)};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // ch3 low at -128 (never below); ch3 therm at -120 (release floors at -128)
        low_lim_bus   = pack4(-40, 0, 25, -128);
        therm_lim_bus = pack4(85, 100, -5, -120);
        for (int ch = 0; ch < NCH; ch++) begin
            m_low[ch] = 0; m_reach[ch] = 0; m_therm[ch] = 0; m_cnt[ch] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rd_data", rd_data, 0);
        chk("R1 low_flag", low_flag, 0);
        chk("R1 therm_flag", therm_flag, 0);
        chk("R1 alert_o", alert_o, 0);
        chk("R1 therm_o", therm_o, 0);
        step(1'b0, '0, 1'b1, 8'h36);
        step(1'b0, '0, 1'b1, 8'h37);

        run_pass(1'b0, 0, 10, 0);
        run_pass(1'b0, 2, 0, 1);
        run_pass(1'b0, 15, 200, 0);
        run_pass(1'b1, 1, 5, 1);
        run_pass(1'b1, 15, 255, 0);
        low_lim_bus   = pack4(127, -1, -100, 10);
        therm_lim_bus = pack4(-128, 0, 127, 50);
        run_pass(1'b0, 3, 30, 1);
        run_pass(1'b1, 0, 1, 1);

        // directed R6: alert_count=2 means three consecutive below conversions
        low_lim_bus   = pack4(0, -40, 25, -128);
        therm_lim_bus = pack4(85, 100, 90, 120);
        comp_mode = 1'b0; alert_count = 4'd2; therm_hyst = 8'd4;
        step(1'b1, pack4(50, 50, 50, 50), 1'b0, 8'h00);
        step(1'b0, '0, 1'b1, 8'h36);
        step(1'b1, pack4(-5, 50, 50, 50), 1'b0, 8'h00); chk("R6 run1", alert_o, 0);
        step(1'b1, pack4(-5, 50, 50, 50), 1'b0, 8'h00); chk("R6 run2", alert_o, 0);
        step(1'b1, pack4(5, 50, 50, 50), 1'b0, 8'h00);  chk("R6 broken", alert_o, 0);
        step(1'b1, pack4(-5, 50, 50, 50), 1'b0, 8'h00); chk("R6 restart1", alert_o, 0);
        step(1'b1, pack4(-5, 50, 50, 50), 1'b0, 8'h00); chk("R6 restart2", alert_o, 0);
        step(1'b1, pack4(-5, 50, 50, 50), 1'b0, 8'h00); chk("R6 qualified", alert_o, 1);

        // directed R4: read-clear and new below event share one edge
        step(1'b1, pack4(-9, 50, 50, 50), 1'b1, 8'h36);
        chk("R4 old content returned", rd_data, 1);
        chk("R4 bit survives", low_flag, 1);
        step(1'b0, '0, 1'b1, 8'h36);
        chk("R4 readback", rd_data, 1);
        chk("R3 cleared after read", low_flag, 0);

        // directed R8: hysteresis hold band for channel 0 (limit 85, hyst 4)
        step(1'b1, pack4(86, 50, 50, 50), 1'b0, 8'h00); chk("R7 set above", therm_o, 1);
        step(1'b1, pack4(81, 50, 50, 50), 1'b0, 8'h00); chk("R8 hold at release", therm_o, 1);
        step(1'b1, pack4(80, 50, 50, 50), 1'b0, 8'h00); chk("R8 cleared below", therm_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule